// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator

This block produces one pulse-width-modulated waveform. The waveform is set by a period value, a duty value, a polarity bit and an alignment select. The channel counter moves only on a clock-enable tick. That tick is picked from one of two prescaled versions of the master clock, so the waveform period scales with the chosen divider. Edge alignment runs the counter upward and wraps it. Center alignment runs it up and then back down, which gives a symmetric pulse in a period twice as long for the same period value.

Polarity and alignment are sampled only while the channel is disabled. Changes made while the channel runs have no effect until it is disabled again. A one-cycle end-of-period pulse marks each period boundary. When the duty value is 0, or at or above the period value, the output holds a constant level.

Top module: `pwm_chan`

## Requirements
- R1: While reset is asserted (rst_n low), `pwm_out` and `eop` are 0, and the latched polarity and alignment take their defaults: polarity 0 and edge alignment.
- R2: On every clock edge where `en` is low, the counter returns to 0 and the latched polarity takes the `pol` input. From the next cycle, `pwm_out` equals that latched polarity.
- R3: While `en` stays high, changes on `pol` and `center` have no effect on `pwm_out`. They take effect only after a clock edge with `en` low.
- R4: With edge alignment (latched `center` = 0), the counter steps 0, 1, ..., P-1 and then wraps to 0. A period lasts P ticks.
- R5: With center alignment (latched `center` = 1), the counter steps up 0..P-1 and then down P-1..0, repeating each end value once. A period lasts 2P ticks, twice the edge-aligned length for the same P.
- R6: While running, `pwm_out` equals the latched polarity when the counter is below `duty`, and its inverse otherwise. A period therefore starts at the polarity level.
- R7: While running, `duty` = 0 holds `pwm_out` at the inverse of the latched polarity, and `duty` >= P holds it at the latched polarity.
- R8: The counter advances only on clock edges where the selected tick is high: `tick_a` when `tick_sel` = 0, `tick_b` when `tick_sel` = 1. The unselected tick is ignored. The edge on which `en` first rises never advances the counter.
- R9: `eop` is high for exactly the one cycle after the edge that consumes the last tick of a period: the wrap in edge mode, or the step from 0 on the down slope in center mode.
- R10: A `period` value of 0 behaves as P = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| pol | input | 1 | Polarity; latched while disabled |
| center | input | 1 | 1 = center alignment, 0 = edge alignment; latched while disabled |
| period | input | W | Period value P |
| duty | input | W | Duty value |
| tick_sel | input | 1 | Tick source select |
| tick_a | input | 1 | Clock-enable tick from the first prescaler |
| tick_b | input | 1 | Clock-enable tick from the second prescaler |
| pwm_out | output | 1 | Waveform output |
| eop | output | 1 | End-of-period pulse |

## Verification
The assertions check on every cycle that:
- the idle level follows polarity while the channel is disabled;
- the latched polarity stays frozen while the channel runs;
- the counter only moves by one step or returns to 0, and holds when no tick arrives;
- `eop` appears only while the channel is enabled;
- a zero duty forces the inverse level.

Only the bench scenarios can show the period lengths of the two alignment modes, the symmetric center-aligned pulse shape, period 0 acting as 1, and tick-source selection. For these, the bench compares every cycle against a model derived from the requirements and measures end-of-period intervals directly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/pwm_tick_mux.sv
module pwm_tick_mux #(
    parameter int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = ticks[i] && (sel == SEL_W'(i));
    end

    assign tick = |hit;

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         pol_in,
    input  logic         center_in,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         pol_lat,
    output logic         eop
);

    typedef struct packed {
        logic [W-1:0] cnt;
        dir_e         dir;
        logic         run;
        logic         pol;
        align_e       align;
        logic         eop;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W-1:0] top_val;

    // Highest count value; period 0 acts as period 1
    assign top_val = (period == '0) ? '0 : period - W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.eop = 1'b0;
        if (!en) begin
            st_d.cnt   = '0;
            st_d.dir   = DIR_UP;
            st_d.run   = 1'b0;
            st_d.pol   = pol_in;
            st_d.align = align_e'(center_in);
        end else begin
            st_d.run = 1'b1;
            if (st_q.run && tick) begin
                if (st_q.align == ALIGN_EDGE) begin
                    if (st_q.cnt >= top_val) begin
                        st_d.cnt = '0;
                        st_d.eop = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + W'(1);
                    end
                end else if (st_q.dir == DIR_UP) begin
                    if (st_q.cnt >= top_val) begin
                        st_d.dir = DIR_DOWN;
                    end else begin
                        st_d.cnt = st_q.cnt + W'(1);
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        st_d.dir = DIR_UP;
                        st_d.eop = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: DIR_UP, run: 1'b0, pol: 1'b0,
                      align: ALIGN_EDGE, eop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign run     = st_q.run;
    assign pol_lat = st_q.pol;
    assign eop     = st_q.eop;

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int W = 16
) (
    input  logic         run,
    input  logic         pol,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    output logic         wave
);

    logic in_duty;

    always_comb begin
        in_duty = (cnt < duty);
        if (!run) begin
            wave = pol;
        end else if (in_duty) begin
            wave = pol;
        end else begin
            wave = !pol;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         pol,
    input  logic         center,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    input  logic         tick_sel,
    input  logic         tick_a,
    input  logic         tick_b,
    output logic         pwm_out,
    output logic         eop
);

    logic         tick_w;
    logic [W-1:0] cnt_w;
    logic         run_w;
    logic         pol_lat_w;

    pwm_tick_mux #(.N_SRC(2)) u_mux (
        .ticks ({tick_b, tick_a}),
        .sel   (tick_sel),
        .tick  (tick_w)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick_w),
        .pol_in    (pol),
        .center_in (center),
        .period    (period),
        .cnt       (cnt_w),
        .run       (run_w),
        .pol_lat   (pol_lat_w),
        .eop       (eop)
    );

    pwm_wave #(.W(W)) u_wave (
        .run  (run_w),
        .pol  (pol_lat_w),
        .cnt  (cnt_w),
        .duty (duty),
        .wave (pwm_out)
    );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         pol,
    input logic         tick_sel,
    input logic         tick_a,
    input logic         tick_b,
    input logic [W-1:0] duty,
    input logic         pwm_out,
    input logic         eop,
    input logic [W-1:0] cnt,
    input logic         pol_lat,
    input logic         run
);

    logic tk;
    assign tk = tick_sel ? tick_b : tick_a;

    // R2: a disabled edge makes the output follow the sampled polarity
    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (pwm_out == $past(pol)));

    // R3: latched polarity frozen while enabled
    p_pol_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> $stable(pol_lat));

    // R4 / R5: counter moves by one step or returns to zero
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == '0 || cnt == $past(cnt) ||
                          cnt == $past(cnt) + W'(1) || cnt == $past(cnt) - W'(1)));

    // R8: no selected tick, no movement
    p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(tk)) |-> ($stable(cnt) && !eop));

    // R9: end-of-period only follows an enabled edge
    p_eop_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> ($past(rst_n) && $past(en)));

    // R7: zero duty forces the inverse level while running
    p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == '0) |-> (pwm_out == !pol_lat));

endmodule

bind pwm_chan pwm_chan_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pol      (pol),
    .tick_sel (tick_sel),
    .tick_a   (tick_a),
    .tick_b   (tick_b),
    .duty     (duty),
    .pwm_out  (pwm_out),
    .eop      (eop),
    .cnt      (cnt_w),
    .pol_lat  (pol_lat_w),
    .run      (run_w)
);

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0, pol = 1'b0, center = 1'b0;
    logic [W-1:0] period = W'(4), duty = W'(2);
    logic         tick_sel = 1'b0, tick_a = 1'b0, tick_b = 1'b0;
    logic         pwm_out, eop;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_chan #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .center(center),
        .period(period), .duty(duty), .tick_sel(tick_sel),
        .tick_a(tick_a), .tick_b(tick_b), .pwm_out(pwm_out), .eop(eop)
    );

    // Reference model built from the requirements
    int  m_cnt, m_top;
    bit  m_up, m_run, m_pol, m_ctr, m_eop;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_up <= 1; m_run <= 0; m_pol <= 0; m_ctr <= 0; m_eop <= 0;
        end else if (!en) begin
            m_cnt <= 0; m_up <= 1; m_run <= 0; m_pol <= pol; m_ctr <= center; m_eop <= 0;
        end else begin
            m_run <= 1;
            m_eop <= 0;
            m_top = (period == 0) ? 0 : int'(period) - 1;  // R10
            if (m_run && (tick_sel ? tick_b : tick_a)) begin
                if (!m_ctr) begin
                    if (m_cnt >= m_top) begin m_cnt <= 0; m_eop <= 1; end
                    else m_cnt <= m_cnt + 1;
                end else if (m_up) begin
                    if (m_cnt >= m_top) m_up <= 0;
                    else m_cnt <= m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_up <= 1; m_eop <= 1; end
                    else m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    function automatic bit exp_out(bit run, bit p, int c, int d);
        if (!run) return p;
        return (c < d) ? p : !p;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison, well away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            string tag;
            if (!m_run) tag = "R2";
            else if (duty == 0 || int'(duty) >= ((period == 0) ? 1 : int'(period))) tag = "R7";
            else if (m_ctr) tag = "R5/R6";
            else tag = "R4/R6";
            check(tag, pwm_out, exp_out(m_run, m_pol, m_cnt, int'(duty)));
            check("R9", eop, m_eop);
        end
    end

    task automatic cfg_run(input bit c, input bit p, input int per, input int d);
        @(negedge clk);
        en = 0; center = c; pol = p; period = W'(per); duty = W'(d);
        tick_sel = 0; tick_a = 1; tick_b = 0;
        @(negedge clk);
        en = 1;
    endtask

    task automatic measure(input string req, input int expv);
        int n = 0;
        int guard = 0;
        while (!eop && guard < 200) begin @(negedge clk); guard++; end
        @(negedge clk); n = 1;
        while (!eop && n < 200) begin @(negedge clk); n++; end
        check(req, n, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit hold;
        process::self().srandom(32'h1234abcd);
        repeat (3) @(negedge clk);
        check("R1", pwm_out, 0);
        check("R1", eop, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R4 edge period, R5 center period, R10 period 0
        cfg_run(0, 0, 5, 2);  measure("R4", 5);
        cfg_run(1, 0, 5, 2);  measure("R5", 10);
        cfg_run(0, 0, 0, 0);  measure("R10", 1);
        cfg_run(1, 1, 1, 0);  measure("R5", 2);

        // R7 fixed levels and R3 polarity lock
        cfg_run(0, 0, 4, 0);
        repeat (3) @(negedge clk);
        #2 check("R7", pwm_out, 1);
        pol = 1; center = 1;
        repeat (6) begin @(negedge clk); #2 check("R3", pwm_out, 1); end
        en = 0;
        @(negedge clk); #2 check("R2", pwm_out, 1);
        cfg_run(0, 1, 4, 9);
        repeat (5) begin @(negedge clk); #2 check("R7", pwm_out, 1); end

        // R8: only the unselected source ticks, so the output must not move
        cfg_run(0, 0, 6, 3);
        tick_a = 0;
        @(negedge clk); @(negedge clk);
        #2 hold = pwm_out;
        tick_b = 1;
        repeat (10) begin @(negedge clk); #2 check("R8", pwm_out, hold); check("R8", eop, 0); end
        tick_sel = 1;
        measure("R8", 6);

        // Constrained random phase
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            tick_a = ($urandom_range(0, 3) != 0);
            tick_b = ($urandom_range(0, 1) != 0);
            if ($urandom_range(0, 7) == 0) tick_sel = $urandom_range(0, 1);
            if ($urandom_range(0, 9) == 0) pol = $urandom_range(0, 1);
            if ($urandom_range(0, 9) == 0) center = $urandom_range(0, 1);
            if ($urandom_range(0, 99) == 0) en = !en;
            if (!en && $urandom_range(0, 3) == 0) begin
                period = W'($urandom_range(0, 12));
                duty   = W'($urandom_range(0, 14));
            end
        end

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule